// File: doc/BRIEF.md
# Reservation-Station Issue Engine

This block schedules two-address arithmetic operations (`dst = dst op src`) out of order over four architectural registers. Operations arrive in program order, wait in an eight-slot queue and leave it in order. Each is placed in a reservation station that belongs to its functional unit. The adder has three stations and the multiply/divide unit has two. A station captures each operand either as a value or as the tag of the station that will produce it. It then waits until both operands hold data, and is then started on its unit.

Results return over one shared result bus that carries a tag and a value. Every register and every station slot that waits on that tag takes the value in the same cycle. Each register records its latest producer, so a later write always replaces an older pending one. The functional units are modelled inside the block as fixed-latency engines on `DATA_W`-bit integers. Addition and subtraction wrap, multiplication keeps the low half of the product, and division is unsigned.

Top module: `fp_issue_engine`

## Requirements
- R1: While reset is held and in the cycle after it is released, register k holds the value k+1, no register is busy, the result bus is idle, `inReady` is high and `idle` is high.
- R2: For any stream of operations, once the engine is idle every register holds the value that executing the stream one operation at a time in program order would give.
- R3: Start-to-broadcast latency is 2 cycles for add and subtract, 3 for multiply and 12 for divide. On an idle engine the result is on the bus after 3, 4 or 13 rising edges following the edge that accepts the operation.
- R4: At most one result is broadcast per cycle. When both units finish in the same cycle, the multiply/divide result goes first and the adder result follows in the next cycle with its tag unchanged.
- R5: At dispatch the destination register becomes busy under the new station's tag. When an older producer of that register broadcasts later, the register stays busy and only the newest producer updates it.
- R6: An operation that reads a register still pending takes its value from the result bus. This holds both when it waits in a station and when the producer broadcasts in the same cycle as the dispatch.
- R7: Dispatch happens in order and stalls only when no station of the needed unit is free. The queue holds 8 operations, and `inReady` is low while it is full. No accepted operation is lost.
- R8: Tags 1 to 3 name the adder stations and tags 4 and 5 name the multiply/divide stations. The lowest free station is allocated, and a broadcast carries the tag of the station that produced it.
- R9: `inOp` is encoded as 0 = add, 1 = multiply, 2 = divide, 3 = subtract (`dst - src`). Subtract runs on the adder.
- R10: Division by zero yields all ones.
- R11: A register stays busy from the dispatch of its producer until that producer's broadcast, and is not busy once the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An operation is offered |
| inOp | input | 2 | Operation code (R9) |
| inDst | input | 2 | Destination and first source register |
| inSrc | input | 2 | Second source register |
| inReady | output | 1 | Queue can accept an operation this cycle |
| busValid | output | 1 | Result bus carries a result |
| busTag | output | 4 | Tag of the station that produced the result |
| busValue | output | DATA_W | Broadcast result value |
| regValue | output | 4*DATA_W | Register contents, register k at bits [k*DATA_W +: DATA_W] |
| regBusy | output | 4 | Register k waits on a pending producer |
| idle | output | 1 | Queue empty and all stations free |

## Verification
The bench drives single operations into an idle engine to pin down the cycle of each latency and the tag of the lowest free station. It times a multiply and an add to finish in the same cycle, so that a wrong bus priority, or an adder that drops or changes its result after losing arbitration, shows as a wrong tag order. A divide followed by a dependent write to the same register checks that the register stays busy after the older broadcast; a design that restores the old tag would release it early and let the stale value win. A zero divisor, a divide-heavy burst that fills the queue, and long pseudo-random streams compared against an in-order model cover division by zero, lost operations under backpressure, and missed same-cycle forwarding at dispatch.

// File: rtl/fpie_pkg.sv
package fpie_pkg;
  localparam int TAG_W    = 4;
  localparam int NUM_REGS = 4;
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int ADD_RS   = 3;
  localparam int MD_RS    = 2;
  localparam int NUM_RS   = ADD_RS + MD_RS;
  localparam int LAT_ADD  = 2;
  localparam int LAT_MUL  = 3;
  localparam int LAT_DIV  = 12;
  localparam int CNT_W    = $clog2(LAT_DIV + 1);

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_DIV = 2'd2,
    OP_SUB = 2'd3
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             dispEn;
    logic [TAG_W-1:0] dispTag;
    opKind_e          dispOp;
    logic [REG_W-1:0] dispDst;
    logic [REG_W-1:0] dispSrc;
    logic             addStart;
    logic [TAG_W-1:0] addSel;
    logic             mdStart;
    logic [TAG_W-1:0] mdSel;
    logic             busValid;
    logic             busFromMd;
    logic [TAG_W-1:0] busTag;
  } strobe_t;

  function automatic logic isMdOp(opKind_e op);
    return (op == OP_MUL) || (op == OP_DIV);
  endfunction
endpackage

// File: rtl/fpie_ctrl.sv
module fpie_ctrl import fpie_pkg::*; #(
  parameter int QDEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inOp,
  input  logic [REG_W-1:0]  inDst,
  input  logic [REG_W-1:0]  inSrc,
  output logic              inReady,
  output logic              queueEmpty,
  input  logic [NUM_RS-1:0] stBusy,
  input  logic [NUM_RS-1:0] stReady,
  input  logic [NUM_RS-1:0] stIsDiv,
  output strobe_t           strb
);
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNT_QW = $clog2(QDEPTH + 1);

  typedef struct packed {
    opKind_e          op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
  } qEntry_t;

  qEntry_t          qMem [QDEPTH];
  qEntry_t          qHeadEnt;
  logic [PTR_W-1:0] qHead, qTail;
  logic [CNT_QW-1:0] qCount;
  logic             push, pop;

  logic             freeFound;
  logic [TAG_W-1:0] freeTag;
  logic             addPick, mdPick, mdPickDiv;
  logic [TAG_W-1:0] addPickTag, mdPickTag;

  logic             addActive, mdActive, addDone, mdDone, addGrant, mdGrant;
  logic [CNT_W-1:0] addCnt, mdCnt;
  logic [TAG_W-1:0] addTag, mdTag;

  // in-order operation queue
  assign inReady    = qCount != CNT_QW'(QDEPTH);
  assign queueEmpty = qCount == '0;
  assign push       = inValid && inReady;
  assign pop        = strb.dispEn;
  assign qHeadEnt   = qMem[qHead];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qHead  <= '0;
      qTail  <= '0;
      qCount <= '0;
    end else begin
      if (push) qTail <= (qTail == PTR_W'(QDEPTH - 1)) ? '0 : qTail + PTR_W'(1);
      if (pop)  qHead <= (qHead == PTR_W'(QDEPTH - 1)) ? '0 : qHead + PTR_W'(1);
      qCount <= qCount + CNT_QW'(push) - CNT_QW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) qMem[qTail] <= '{op: opKind_e'(inOp), dst: inDst, src: inSrc};
  end

  // lowest free station of the unit the head operation needs
  always_comb begin
    freeFound = 1'b0;
    freeTag   = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (!freeFound && !stBusy[i] && (isMdOp(qHeadEnt.op) == (i >= ADD_RS))) begin
        freeFound = 1'b1;
        freeTag   = TAG_W'(i + 1);
      end
    end
  end

  // lowest ready station per unit
  always_comb begin
    addPick    = 1'b0;
    addPickTag = '0;
    mdPick     = 1'b0;
    mdPickTag  = '0;
    mdPickDiv  = 1'b0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (stReady[i]) begin
        if (i < ADD_RS) begin
          if (!addPick) begin
            addPick    = 1'b1;
            addPickTag = TAG_W'(i + 1);
          end
        end else if (!mdPick) begin
          mdPick    = 1'b1;
          mdPickTag = TAG_W'(i + 1);
          mdPickDiv = stIsDiv[i];
        end
      end
    end
  end

  // functional-unit timing and bus arbitration, multiply/divide first
  assign addDone  = addActive && (addCnt == '0);
  assign mdDone   = mdActive && (mdCnt == '0);
  assign mdGrant  = mdDone;
  assign addGrant = addDone && !mdDone;

  always_comb begin
    strb           = '0;
    strb.dispEn    = !queueEmpty && freeFound;
    strb.dispTag   = freeTag;
    strb.dispOp    = qHeadEnt.op;
    strb.dispDst   = qHeadEnt.dst;
    strb.dispSrc   = qHeadEnt.src;
    strb.addStart  = addPick && (!addActive || addGrant);
    strb.addSel    = addPickTag;
    strb.mdStart   = mdPick && (!mdActive || mdGrant);
    strb.mdSel     = mdPickTag;
    strb.busValid  = addDone || mdDone;
    strb.busFromMd = mdDone;
    strb.busTag    = mdDone ? mdTag : addTag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addActive <= 1'b0;
      addCnt    <= '0;
      addTag    <= '0;
      mdActive  <= 1'b0;
      mdCnt     <= '0;
      mdTag     <= '0;
    end else begin
      if (strb.addStart) begin
        addActive <= 1'b1;
        addCnt    <= CNT_W'(LAT_ADD - 1);
        addTag    <= addPickTag;
      end else if (addGrant) begin
        addActive <= 1'b0;
      end else if (addActive && addCnt != '0) begin
        addCnt <= addCnt - CNT_W'(1);
      end
      if (strb.mdStart) begin
        mdActive <= 1'b1;
        mdCnt    <= mdPickDiv ? CNT_W'(LAT_DIV - 1) : CNT_W'(LAT_MUL - 1);
        mdTag    <= mdPickTag;
      end else if (mdGrant) begin
        mdActive <= 1'b0;
      end else if (mdActive && mdCnt != '0) begin
        mdCnt <= mdCnt - CNT_W'(1);
      end
    end
  end

  a_r7_queue_bound: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_QW'(QDEPTH));
  a_r3_add_latency: assert property (@(posedge clk) disable iff (!rstN)
    strb.addStart |-> ##2 addDone);
  a_r3_mul_latency: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mdStart && !mdPickDiv) |-> ##3 mdDone);
  a_r3_div_latency: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mdStart && mdPickDiv) |-> ##12 mdDone);
  a_r4_loser_held: assert property (@(posedge clk) disable iff (!rstN)
    (addDone && mdDone) |=> (addDone && $stable(addTag)));
endmodule

// File: rtl/fpie_dpath.sv
module fpie_dpath import fpie_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  output logic [NUM_RS-1:0]          stBusy,
  output logic [NUM_RS-1:0]          stReady,
  output logic [NUM_RS-1:0]          stIsDiv,
  output logic [DATA_W-1:0]          busValue,
  output logic [NUM_REGS*DATA_W-1:0] regValue,
  output logic [NUM_REGS-1:0]        regBusyOut
);
  typedef struct packed {
    logic              busy;
    logic              issued;
    opKind_e           op;
    logic [TAG_W-1:0]  sinkTag;
    logic [DATA_W-1:0] sinkVal;
    logic [TAG_W-1:0]  srcTag;
    logic [DATA_W-1:0] srcVal;
  } station_t;

  station_t          rs [NUM_RS];
  logic [NUM_REGS-1:0] rBusy;
  logic [TAG_W-1:0]  rTag [NUM_REGS];
  logic [DATA_W-1:0] rVal [NUM_REGS];

  logic [TAG_W-1:0]  sinkTagN, srcTagN;
  logic [DATA_W-1:0] sinkValN, srcValN;
  logic [DATA_W-1:0] addA, addB, mdA, mdB, addRes, mdRes;
  opKind_e           addOp, mdOp;
  logic              ownerLive, targetBusy;

  function automatic logic [DATA_W-1:0] calc(opKind_e op, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_MUL:  r = a * b;
      default: r = (b == '0) ? '1 : a / b;
    endcase
    return r;
  endfunction

  assign busValue = strb.busFromMd ? mdRes : addRes;

  // operand read at dispatch, with bypass from the bus
  always_comb begin
    sinkTagN = rTag[strb.dispDst];
    sinkValN = rVal[strb.dispDst];
    if (!rBusy[strb.dispDst]) begin
      sinkTagN = '0;
    end else if (strb.busValid && rTag[strb.dispDst] == strb.busTag) begin
      sinkTagN = '0;
      sinkValN = busValue;
    end
    srcTagN = rTag[strb.dispSrc];
    srcValN = rVal[strb.dispSrc];
    if (!rBusy[strb.dispSrc]) begin
      srcTagN = '0;
    end else if (strb.busValid && rTag[strb.dispSrc] == strb.busTag) begin
      srcTagN = '0;
      srcValN = busValue;
    end
  end

  // station status and operand selection for the units
  always_comb begin
    addA = '0; addB = '0; addOp = OP_ADD;
    mdA  = '0; mdB  = '0; mdOp  = OP_MUL;
    ownerLive  = 1'b0;
    targetBusy = 1'b0;
    for (int i = 0; i < NUM_RS; i++) begin
      stBusy[i]  = rs[i].busy;
      stReady[i] = rs[i].busy && !rs[i].issued && rs[i].sinkTag == '0 && rs[i].srcTag == '0;
      stIsDiv[i] = rs[i].op == OP_DIV;
      if (strb.addSel == TAG_W'(i + 1)) begin
        addA = rs[i].sinkVal; addB = rs[i].srcVal; addOp = rs[i].op;
      end
      if (strb.mdSel == TAG_W'(i + 1)) begin
        mdA = rs[i].sinkVal; mdB = rs[i].srcVal; mdOp = rs[i].op;
      end
      if (strb.busTag == TAG_W'(i + 1))  ownerLive  = rs[i].busy && rs[i].issued;
      if (strb.dispTag == TAG_W'(i + 1)) targetBusy = rs[i].busy;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addRes <= '0;
      mdRes  <= '0;
    end else begin
      if (strb.addStart) addRes <= calc(addOp, addA, addB);
      if (strb.mdStart)  mdRes  <= calc(mdOp, mdA, mdB);
    end
  end

  // reservation stations
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RS; i++) rs[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_RS; i++) begin
        if (strb.dispEn && strb.dispTag == TAG_W'(i + 1)) begin
          rs[i] <= '{busy: 1'b1, issued: 1'b0, op: strb.dispOp,
                     sinkTag: sinkTagN, sinkVal: sinkValN,
                     srcTag: srcTagN, srcVal: srcValN};
        end else begin
          if (strb.busValid && strb.busTag == TAG_W'(i + 1)) rs[i].busy <= 1'b0;
          if ((strb.addStart && strb.addSel == TAG_W'(i + 1)) ||
              (strb.mdStart && strb.mdSel == TAG_W'(i + 1))) rs[i].issued <= 1'b1;
          if (strb.busValid && rs[i].sinkTag != '0 && rs[i].sinkTag == strb.busTag) begin
            rs[i].sinkTag <= '0;
            rs[i].sinkVal <= busValue;
          end
          if (strb.busValid && rs[i].srcTag != '0 && rs[i].srcTag == strb.busTag) begin
            rs[i].srcTag <= '0;
            rs[i].srcVal <= busValue;
          end
        end
      end
    end
  end

  // architectural registers with producer tags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        rBusy[r] <= 1'b0;
        rTag[r]  <= '0;
        rVal[r]  <= DATA_W'(r + 1);
      end
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strb.dispEn && strb.dispDst == REG_W'(r)) begin
          rBusy[r] <= 1'b1;
          rTag[r]  <= strb.dispTag;
        end else if (strb.busValid && rBusy[r] && rTag[r] == strb.busTag) begin
          rBusy[r] <= 1'b0;
          rTag[r]  <= '0;
          rVal[r]  <= busValue;
        end
      end
    end
  end

  assign regBusyOut = rBusy;
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    assign regValue[g*DATA_W +: DATA_W] = rVal[g];

    a_r5_rename: assert property (@(posedge clk) disable iff (!rstN)
      (strb.dispEn && strb.dispDst == REG_W'(g)) |=> (rBusy[g] && rTag[g] == $past(strb.dispTag)));
    a_r11_release: assert property (@(posedge clk) disable iff (!rstN)
      (strb.busValid && rBusy[g] && rTag[g] == strb.busTag &&
       !(strb.dispEn && strb.dispDst == REG_W'(g))) |=> (!rBusy[g] && rVal[g] == $past(busValue)));
  end

  a_r8_owner_live: assert property (@(posedge clk) disable iff (!rstN)
    strb.busValid |-> (strb.busTag != '0 && ownerLive));
  a_r7_free_target: assert property (@(posedge clk) disable iff (!rstN)
    strb.dispEn |-> !targetBusy);
endmodule

// File: rtl/fp_issue_engine.sv
module fp_issue_engine import fpie_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int QDEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [1:0]                 inOp,
  input  logic [REG_W-1:0]           inDst,
  input  logic [REG_W-1:0]           inSrc,
  output logic                       inReady,
  output logic                       busValid,
  output logic [TAG_W-1:0]           busTag,
  output logic [DATA_W-1:0]          busValue,
  output logic [NUM_REGS*DATA_W-1:0] regValue,
  output logic [NUM_REGS-1:0]        regBusy,
  output logic                       idle
);
  strobe_t           strb;
  logic [NUM_RS-1:0] stBusy, stReady, stIsDiv;
  logic              queueEmpty;

  fpie_ctrl #(.QDEPTH(QDEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inOp(inOp), .inDst(inDst), .inSrc(inSrc),
    .inReady(inReady), .queueEmpty(queueEmpty),
    .stBusy(stBusy), .stReady(stReady), .stIsDiv(stIsDiv),
    .strb(strb)
  );

  fpie_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .stBusy(stBusy), .stReady(stReady), .stIsDiv(stIsDiv),
    .busValue(busValue), .regValue(regValue), .regBusyOut(regBusy)
  );

  assign busValid = strb.busValid;
  assign busTag   = strb.busTag;
  assign idle     = queueEmpty && (stBusy == '0);
endmodule

// File: tb/test_fp_issue_engine.sv
module test_fp_issue_engine;
  import fpie_pkg::*;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic                  inValid = 1'b0;
  logic [1:0]            inOp = '0;
  logic [REG_W-1:0]      inDst = '0, inSrc = '0;
  logic                  inReady, busValid, idle;
  logic [TAG_W-1:0]      busTag;
  logic [W-1:0]          busValue;
  logic [NUM_REGS*W-1:0] regValue;
  logic [NUM_REGS-1:0]   regBusy;

  int nVec = 0, nBad = 0, stallSeen = 0;
  bit finished = 1'b0;
  logic [W-1:0] mdl [NUM_REGS];

  fp_issue_engine #(.DATA_W(W), .QDEPTH(8)) i_fp_issue_engine (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inDst(inDst), .inSrc(inSrc),
    .inReady(inReady), .busValid(busValid), .busTag(busTag), .busValue(busValue),
    .regValue(regValue), .regBusy(regBusy), .idle(idle)
  );

  function automatic logic [W-1:0] refOp(int op, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] r;
    case (op)
      0: r = a + b;
      1: r = a * b;
      2: r = (b == '0) ? {W{1'b1}} : a / b;
      default: r = a - b;
    endcase
    return r;
  endfunction

  function automatic logic [W-1:0] regOf(int r);
    return regValue[r*W +: W];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic pushOp(int op, int d, int s);
    while (!inReady) begin
      stallSeen++;
      @(negedge clk);
    end
    inValid = 1'b1;
    inOp  = op[1:0];
    inDst = d[REG_W-1:0];
    inSrc = s[REG_W-1:0];
    @(negedge clk);
    inValid = 1'b0;
    mdl[d] = refOp(op, mdl[d], mdl[s]);
  endtask

  task automatic drain();
    int k = 0;
    while (!idle && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic waitBus(output int k);
    k = 0;
    while (!busValid && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic compareAll(string req);
    drain();
    for (int r = 0; r < NUM_REGS; r++) check(req, 32'(regOf(r)), 32'(mdl[r]));
    check("R11 no busy register when idle", 32'(regBusy), 32'd0);
  endtask

  initial begin
    int k;
    logic [15:0] lfsr;
    for (int r = 0; r < NUM_REGS; r++) mdl[r] = W'(r + 1);
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int r = 0; r < NUM_REGS; r++) check("R1 reset value", 32'(regOf(r)), 32'(r + 1));
    check("R1 reset busy", 32'(regBusy), 32'd0);
    check("R1 reset bus", 32'(busValid), 32'd0);
    check("R1 reset ready", 32'(inReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(idle), 32'd1);

    // R3, R8, R9: isolated operations on an idle engine
    pushOp(0, 0, 1);
    waitBus(k);
    check("R3 add latency", 32'(k), 32'd3);
    check("R8 first adder tag", 32'(busTag), 32'd1);
    check("R9 add value", 32'(busValue), 32'(mdl[0]));
    check("R11 busy while pending", 32'(regBusy[0]), 32'd1);
    drain();
    pushOp(1, 2, 3);
    waitBus(k);
    check("R3 mul latency", 32'(k), 32'd4);
    check("R8 first muldiv tag", 32'(busTag), 32'd4);
    check("R9 mul value", 32'(busValue), 32'(mdl[2]));
    drain();
    pushOp(2, 3, 0);
    waitBus(k);
    check("R3 div latency", 32'(k), 32'd13);
    check("R9 div value", 32'(busValue), 32'(mdl[3]));
    compareAll("R2 after single ops");

    // R4: multiply and add finish in the same cycle
    pushOp(1, 0, 1);
    pushOp(0, 2, 3);
    waitBus(k);
    check("R4 collision cycle", 32'(k), 32'd3);
    check("R4 muldiv wins", 32'(busTag), 32'd4);
    @(negedge clk);
    check("R4 adder follows valid", 32'(busValid), 32'd1);
    check("R4 adder follows tag", 32'(busTag), 32'd1);
    compareAll("R4 values");

    // R5: newer writer keeps the register busy past the older broadcast
    pushOp(2, 0, 1);
    pushOp(0, 0, 2);
    waitBus(k);
    check("R5 older producer tag", 32'(busTag), 32'd4);
    @(negedge clk);
    check("R5 register still busy", 32'(regBusy[0]), 32'd1);
    compareAll("R5 final values");

    // R10: divide by zero; R9 subtract
    pushOp(3, 1, 1);
    pushOp(2, 3, 1);
    compareAll("R9 R10 values");
    check("R10 all ones", 32'(regOf(3)), 32'hffff);

    // R6: dependent chain forwarded over the bus
    pushOp(0, 1, 0);
    pushOp(0, 0, 2);
    pushOp(1, 2, 0);
    pushOp(3, 3, 2);
    pushOp(0, 1, 3);
    compareAll("R6 chain");

    // R7: divide-heavy burst fills the queue
    stallSeen = 0;
    for (int i = 0; i < 14; i++) pushOp((i % 2 == 1) ? 2 : 1, i % 4, (i + 1) % 4);
    check("R7 backpressure seen", 32'(stallSeen > 0), 32'd1);
    compareAll("R7 burst values");

    // R2 sweep with pseudo-random streams
    lfsr = 16'hace1;
    for (int round = 0; round < 8; round++) begin
      for (int n = 0; n < 40; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pushOp(int'(lfsr[1:0]), int'(lfsr[3:2]), int'(lfsr[5:4]));
      end
      compareAll("R2 sweep");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog: actual hung expected idle");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule